// File: doc/BRIEF.md
# Collision Back-off Timer

This block decides how long a half-duplex Ethernet transmitter must wait before it tries again after a collision. It counts the collisions suffered by the current frame, draws a random number of slot times whose range doubles with each collision up to a ceiling, and counts those slots down on a slot-time strobe supplied by the MAC. While the countdown runs, the block reports that it is busy and withholds permission to retry. When a frame collides too many times, the block drops the back-off, pulses an abort and starts counting again from zero.

Three diagnostic hooks are included. First, the countdown can be told to freeze while carrier is sensed. Second, a forced-collision mode makes every attempt collide, but only when the loopback bits select internal FIFO loopback. Third, a repeatable pseudo-random sequence can stand in for the free-running random source, so that a test can predict every back-off.

Top module: `backoff_timer`

## Requirements
- R1: After reset, busy is 0, retry_ok is 1, attempt_cnt is 0 and both excess_abort and force_col_req are 0.
- R2: A collision accepted while not busy raises attempt_cnt by one in the following cycle. This applies to col_evt, and to a forced collision (see R9).
- R3: After the n-th collision, with n below 16, the countdown loads r = rnd[9:0] AND (2^min(n,10) - 1). Busy then stays high until exactly r slot_tick cycles have been counted. busy is 1 when r is nonzero and 0 when r is zero, and retry_ok is always the inverse of busy.
- R4: When crs_pause_en is 1 and crs is 1, slot_tick does not decrement the countdown. Counting resumes once crs falls.
- R5: When crs_pause_en is 0, the countdown decrements on every slot_tick whatever the level of crs.
- R6: With prng_sel = 1, rnd comes from a 16-bit shift register. It is reset to 16'hACE1 and shifts left once per draw, taking into bit 0 the XOR of bits 15, 13, 12 and 10. Each draw uses the value held before that shift.
- R7: A tx_start accepted while not busy, when an earlier accepted tx_start has seen no collision since, clears attempt_cnt to 0.
- R8: While busy, col_evt and tx_start are ignored: attempt_cnt and the countdown do not change.
- R9: Forced collision applies only when force_col_en is 1 and lb_mode is 2'b01 (bit 0 set, bit 1 clear). In that case an accepted tx_start counts as a collision, and force_col_req pulses high in the following cycle. In every other lb_mode value, tx_start raises no force_col_req and causes no collision.
- R10: The 16th collision of a frame loads no back-off. It pulses excess_abort high for exactly one cycle and returns attempt_cnt to 0 in that same cycle.
- R11: With prng_sel = 0, the back-off after the n-th collision lasts at most 2^min(n,10) - 1 slot ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_tick | input | 1 | One-cycle strobe per slot time (512 bit times) |
| col_evt | input | 1 | Collision detected on the current attempt |
| crs | input | 1 | Carrier sense |
| tx_start | input | 1 | Transmit attempt begins |
| lb_mode | input | 2 | Loopback select; 2'b01 is internal FIFO loopback |
| crs_pause_en | input | 1 | Freeze countdown while carrier is present |
| force_col_en | input | 1 | Force a collision on every attempt (loopback only) |
| prng_sel | input | 1 | 1 selects the repeatable pseudo-random source |
| busy | output | 1 | Back-off countdown in progress |
| retry_ok | output | 1 | Transmitter may attempt again |
| attempt_cnt | output | 5 | Collisions counted for the current frame |
| excess_abort | output | 1 | One-cycle pulse on the 16th collision |
| force_col_req | output | 1 | One-cycle request to the transmitter to force a collision |

## Verification
A corrupt attempt count shows up right away on attempt_cnt. It also widens or narrows the draw mask, so in repeatable mode the very next back-off has the wrong length. A countdown that skips, stalls or ignores the pause shows up as a busy window with the wrong number of slot ticks, which can be seen as soon as busy falls. A faulty repeatable sequence changes the first back-off after reset. A faulty gate on the forced-collision path lets force_col_req appear in the wrong loopback mode on the cycle after tx_start.

// File: rtl/backoff_pkg.sv
// Package: shared constants for the collision back-off timer.
// Assumes one 16-bit maximal-length polynomial for both random sources.
package backoff_pkg;
    localparam int          LFSR_WIDTH   = 16;
    localparam logic [15:0] LFSR_TAPMASK = 16'hB400;  // bits 15,13,12,10
    localparam logic [15:0] SEED_DET     = 16'hACE1;
    localparam logic [15:0] SEED_FREE    = 16'h0001;
    localparam logic [1:0]  LB_FIFO_INT  = 2'b01;     // bit0 set, bit1 clear
endpackage

// File: rtl/bo_lfsr.sv
// Module: bo_lfsr
// Fibonacci shift register used as a random source. When FREE_RUN is 1 it
// shifts on every clock. Otherwise it shifts only when step is high.
// Assumes SEED is nonzero and TAPS gives a maximal-length sequence.
module bo_lfsr #(
    parameter int              W     = 16,
    parameter int              OUT_W = 10,
    parameter logic [W-1:0]    TAPS  = 16'hB400,
    parameter logic [W-1:0]    SEED  = 16'hACE1,
    parameter bit              FREE_RUN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] state;
    logic         fb;
    logic         adv;

    // Feedback bit: parity of the tapped positions.
    always_comb fb = ^(state & TAPS);

    // Choose when the register advances.
    generate
        if (FREE_RUN) begin : g_free
            always_comb adv = 1'b1;
        end else begin : g_step
            always_comb adv = step;
        end
    endgenerate

    // Shift register update with synchronous reseed.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= SEED;
        else if (adv) state <= {state[W-2:0], fb};
    end

    always_comb rnd = state[OUT_W-1:0];

    // A maximal sequence never reaches the all-zero lock-up state.
    assert_state_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/bo_attempt_ctr.sv
// Module: bo_attempt_ctr
// Counts the collisions of the current frame. On each accepted collision it
// either asks for a back-off draw or, at the limit, raises a one-cycle abort
// and starts over. A success report clears the count.
// Assumes col_hit and success are already qualified by the caller.
module bo_attempt_ctr #(
    parameter int MAX_ATT = 16,
    parameter int LIMIT   = 10,
    parameter int AW      = $clog2(MAX_ATT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          col_hit,
    input  logic          success,
    output logic [AW-1:0] attempt,
    output logic          abort,
    output logic          draw,
    output logic [AW-1:0] draw_exp
);
    logic [AW-1:0] n_next;
    logic          at_limit;

    // Next attempt number, and whether it reaches the abort limit.
    always_comb begin
        n_next   = attempt + 1'b1;
        at_limit = (n_next == AW'(MAX_ATT));
        draw     = col_hit && !at_limit;
        draw_exp = (n_next > AW'(LIMIT)) ? AW'(LIMIT) : n_next;
    end

    // Update the count and the abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attempt <= '0;
            abort   <= 1'b0;
        end else begin
            abort <= 1'b0;
            if (col_hit) begin
                if (at_limit) begin
                    attempt <= '0;
                    abort   <= 1'b1;
                end else begin
                    attempt <= n_next;
                end
            end else if (success) begin
                attempt <= '0;
            end
        end
    end

    assert_below_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        attempt < AW'(MAX_ATT));
    assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> attempt == '0);
    assert_abort_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);
endmodule

// File: rtl/bo_countdown.sv
// Module: bo_countdown
// Slot countdown. It loads a value, then decrements once per tick unless hold
// is asserted, and reports busy while the count is nonzero.
// Assumes the caller never loads while busy.
module bo_countdown #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    input  logic          hold,
    output logic          busy,
    output logic [CW-1:0] count
);
    // Load has priority; otherwise step down on an unheld tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                            count <= '0;
        else if (load)                         count <= load_val;
        else if (tick && count != '0 && !hold) count <= count - 1'b1;
    end

    always_comb busy = (count != '0);

    assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load && count != '0) |=> count == $past(count));
    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count != '0) |=> (count == $past(count) || count == $past(count) - 1'b1));
endmodule

// File: rtl/backoff_timer.sv
// Module: backoff_timer (top)
// Half-duplex retransmission back-off. It qualifies collisions and attempts,
// picks the random source, masks the draw to the current range and runs the
// slot countdown. It also owns the forced-collision loopback test hook.
// Assumes slot_tick is a one-cycle strobe and col_evt follows tx_start.
module backoff_timer #(
    parameter int MAX_ATTEMPTS  = 16,
    parameter int BACKOFF_LIMIT = 10,
    localparam int AW = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_tick,
    input  logic          col_evt,
    input  logic          crs,
    input  logic          tx_start,
    input  logic [1:0]    lb_mode,
    input  logic          crs_pause_en,
    input  logic          force_col_en,
    input  logic          prng_sel,
    output logic          busy,
    output logic          retry_ok,
    output logic [AW-1:0] attempt_cnt,
    output logic          excess_abort,
    output logic          force_col_req
);
    import backoff_pkg::*;

    localparam int CW = BACKOFF_LIMIT;

    logic          force_act, tx_acc, col_acc, success;
    logic          in_flight;
    logic          draw;
    logic [AW-1:0] draw_exp;
    logic [CW-1:0] rnd_free, rnd_det, rnd_sel, rmask, load_val;
    logic [CW-1:0] count;

    // Qualify inputs: nothing is accepted during a back-off.
    always_comb begin
        force_act = force_col_en && (lb_mode == LB_FIFO_INT);
        tx_acc    = tx_start && !busy;
        col_acc   = !busy && (col_evt || (tx_start && force_act));
        success   = tx_acc && in_flight && !col_acc;
    end

    // Track whether an attempt is outstanding without a collision.
    always_ff @(posedge clk) begin
        if (!rst_n)       in_flight <= 1'b0;
        else if (col_acc) in_flight <= 1'b0;
        else if (tx_acc)  in_flight <= 1'b1;
    end

    // Forced-collision request to the transmitter, one cycle after start.
    always_ff @(posedge clk) begin
        if (!rst_n) force_col_req <= 1'b0;
        else        force_col_req <= tx_acc && force_act;
    end

    bo_attempt_ctr #(.MAX_ATT(MAX_ATTEMPTS), .LIMIT(BACKOFF_LIMIT), .AW(AW)) u_att (
        .clk(clk), .rst_n(rst_n), .col_hit(col_acc), .success(success),
        .attempt(attempt_cnt), .abort(excess_abort),
        .draw(draw), .draw_exp(draw_exp)
    );

    bo_lfsr #(.W(LFSR_WIDTH), .OUT_W(CW), .TAPS(LFSR_TAPMASK),
              .SEED(SEED_FREE), .FREE_RUN(1'b1)) u_rng_free (
        .clk(clk), .rst_n(rst_n), .step(1'b0), .rnd(rnd_free)
    );

    bo_lfsr #(.W(LFSR_WIDTH), .OUT_W(CW), .TAPS(LFSR_TAPMASK),
              .SEED(SEED_DET), .FREE_RUN(1'b0)) u_rng_det (
        .clk(clk), .rst_n(rst_n), .step(draw && prng_sel), .rnd(rnd_det)
    );

    // Range mask of min(n, limit) low ones, applied to the chosen source.
    always_comb begin
        for (int i = 0; i < CW; i++) rmask[i] = (i < int'(draw_exp));
        rnd_sel  = prng_sel ? rnd_det : rnd_free;
        load_val = rnd_sel & rmask;
    end

    bo_countdown #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(draw), .load_val(load_val),
        .tick(slot_tick), .hold(crs_pause_en && crs),
        .busy(busy), .count(count)
    );

    always_comb retry_ok = !busy;

    assert_force_only_loopback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_col_req |-> $past(force_col_en && lb_mode == LB_FIFO_INT && tx_start));
    assert_busy_ignores_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !excess_abort) |=> attempt_cnt == $past(attempt_cnt));
    assert_free_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slot_tick && !crs_pause_en) |=> count == $past(count) - 1'b1);
endmodule

// File: tb/backoff_timer_test.sv
// Directed bench for backoff_timer: one task per scenario, each checking itself.
module backoff_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_tick = 0, col_evt = 0, crs = 0, tx_start = 0;
    logic [1:0] lb_mode = 2'b00;
    logic crs_pause_en = 0, force_col_en = 0, prng_sel = 0;
    logic busy, retry_ok, excess_abort, force_col_req;
    logic [4:0] attempt_cnt;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [15:0] det_state;

    always #4 clk = ~clk;  // 125 MHz

    backoff_timer uut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .col_evt(col_evt),
        .crs(crs), .tx_start(tx_start), .lb_mode(lb_mode),
        .crs_pause_en(crs_pause_en), .force_col_en(force_col_en),
        .prng_sel(prng_sel), .busy(busy), .retry_ok(retry_ok),
        .attempt_cnt(attempt_cnt), .excess_abort(excess_abort),
        .force_col_req(force_col_req)
    );

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int range_mask(input int n);
        int k = (n > 10) ? 10 : n;
        return (1 << k) - 1;
    endfunction

    // Deterministic draw as stated in R3/R6, advancing the model.
    function automatic int model_draw(input int n);
        int r = int'(det_state[9:0]) & range_mask(n);
        det_state = model_next(det_state);
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 0; slot_tick = 0; col_evt = 0; crs = 0; tx_start = 0;
        lb_mode = 2'b00; crs_pause_en = 0; force_col_en = 0; prng_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        det_state = 16'hACE1;
        @(negedge clk);
    endtask

    task automatic pulse_col();
        col_evt = 1; @(negedge clk); col_evt = 0;
    endtask

    task automatic pulse_tx();
        tx_start = 1; @(negedge clk); tx_start = 0;
    endtask

    // Count slot ticks until busy drops.
    task automatic drain(output int ticks);
        ticks = 0;
        while (busy && ticks < 1100) begin
            slot_tick = 1; @(negedge clk); ticks++;
        end
        slot_tick = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(busy == 0 && retry_ok == 1, "R1 busy/retry", {busy, retry_ok}, 1);
        chk(attempt_cnt == 0, "R1 attempt", attempt_cnt, 0);
        chk(excess_abort == 0 && force_col_req == 0, "R1 pulses",
            {excess_abort, force_col_req}, 0);
    endtask

    task automatic t_det_draws();
        int r, t;
        do_reset(); prng_sel = 1;
        for (int n = 1; n <= 12; n++) begin
            pulse_col();
            r = model_draw(n);
            chk(attempt_cnt == n, "R2 attempt increment", attempt_cnt, n);
            chk(busy == (r != 0) && retry_ok == !busy, "R3 busy/retry after draw", busy, r != 0);
            drain(t);
            chk(t == r, "R6 R3 repeatable back-off length", t, r);
        end
    endtask

    task automatic t_pause();
        int r, t;
        do_reset(); prng_sel = 1; crs_pause_en = 1;
        pulse_col(); r = model_draw(1);
        chk(r > 0, "R4 setup draw nonzero", r, 1);
        crs = 1; slot_tick = 1;
        repeat (20) @(negedge clk);
        slot_tick = 0;
        chk(busy == 1, "R4 frozen under carrier", busy, 1);
        crs = 0;
        drain(t);
        chk(t == r, "R4 resumes after carrier", t, r);
    endtask

    task automatic t_nopause();
        int r, t;
        do_reset(); prng_sel = 1; crs = 1;
        for (int n = 1; n <= 4; n++) begin
            pulse_col(); r = model_draw(n);
            drain(t);
            chk(t == r, "R5 carrier ignored", t, r);
        end
        crs = 0;
    endtask

    task automatic t_success();
        int t;
        do_reset(); prng_sel = 1;
        for (int n = 1; n <= 3; n++) begin
            pulse_col(); void'(model_draw(n)); drain(t);
        end
        pulse_tx();
        chk(attempt_cnt == 3, "R7 first start keeps count", attempt_cnt, 3);
        pulse_tx();
        chk(attempt_cnt == 0, "R7 success clears count", attempt_cnt, 0);
    endtask

    task automatic t_busy_ignore();
        int r, t;
        do_reset(); prng_sel = 1;
        pulse_col(); r = model_draw(1);
        chk(busy == 1, "R8 setup busy", busy, 1);
        pulse_col();
        pulse_tx();
        chk(attempt_cnt == 1, "R8 collision ignored while busy", attempt_cnt, 1);
        drain(t);
        chk(t == r, "R8 countdown untouched", t, r);
    endtask

    task automatic t_forced();
        int t;
        do_reset(); prng_sel = 1; force_col_en = 1; lb_mode = 2'b01;
        for (int k = 1; k <= 16; k++) begin
            pulse_tx();
            chk(force_col_req == 1, "R9 forced request", force_col_req, 1);
            if (k < 16) begin
                void'(model_draw(k));
                chk(attempt_cnt == k, "R9 forced attempt counts", attempt_cnt, k);
                chk(excess_abort == 0, "R10 no early abort", excess_abort, 0);
            end else begin
                chk(excess_abort == 1, "R10 abort on 16th", excess_abort, 1);
                chk(attempt_cnt == 0, "R10 count cleared", attempt_cnt, 0);
                chk(busy == 0, "R10 no back-off", busy, 0);
            end
            drain(t);
        end
        @(negedge clk);
        chk(excess_abort == 0, "R10 abort one cycle", excess_abort, 0);
    endtask

    task automatic t_force_ignored();
        do_reset(); force_col_en = 1;
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            lb_mode = 2'(m);
            pulse_tx();
            chk(force_col_req == 0, "R9 no request outside loopback", force_col_req, 0);
            chk(attempt_cnt == 0 && busy == 0, "R9 no forced collision", attempt_cnt, 0);
        end
    endtask

    task automatic t_free();
        int t;
        do_reset(); prng_sel = 0;
        for (int n = 1; n <= 12; n++) begin
            repeat (n * 3) @(negedge clk);
            pulse_col();
            drain(t);
            chk(t <= range_mask(n), "R11 free draw in range", t, range_mask(n));
        end
    endtask

    initial begin
        t_reset();
        t_det_draws();
        t_pause();
        t_nopause();
        t_success();
        t_busy_ignore();
        t_forced();
        t_force_ignored();
        t_free();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule